// File: doc/BRIEF.md
# Bit-Test Execute and Timing Unit

This unit carries out the execute step of a bit-test instruction in a small 8/16-bit accumulator processor core. The core hands over a request made of the opcode byte, an accumulator-width mode bit, the accumulator, the operand already fetched from memory or the instruction stream, the low byte of the direct page register, the unindexed base address and X index of the indexed-absolute form, and the current status byte. The unit returns a new status byte, the instruction length in bytes, the total cycle count with every timing penalty included, and an invalid-opcode indication.

The accumulator and the operand are ANDed only to set the zero flag, and the result is never written back. The negative and overflow flags are copied from the two top bits of the operand, except in the immediate form. A one-request handshake captures the inputs on `start` while the unit is idle. The unit raises `done` for one cycle after exactly the computed number of cycles. The outputs then stay valid until the next request is accepted.

Top module: `bit_test_unit`

## Requirements
- R1: Five opcodes are recognised: 0x89 immediate, 0x2C absolute, 0x24 direct page, 0x3C absolute indexed by X, 0x34 direct page indexed by X. Their lengths are 2, 3, 2, 3 and 2 bytes, except that the immediate form is 3 bytes when the accumulator is 16 bits wide.
- R2: Z (status bit 1) is set when accumulator AND operand is zero and cleared otherwise. With `accNarrow` = 1 only the low 8 bits take part. With `accNarrow` = 0 all 16 bits take part.
- R3: In the four non-immediate forms, N (status bit 7) takes operand bit 7 and V (status bit 6) takes operand bit 6 when `accNarrow` = 1, or bits 15 and 14 when `accNarrow` = 0. In the immediate form, N and V keep their input values.
- R4: Status bits 5, 4, 3, 2 and 0 (M, X, D, I, C) always leave the unit equal to `flagsIn`.
- R5: Base cycle counts are 2 (0x89), 4 (0x2C), 3 (0x24), 4 (0x3C) and 4 (0x34).
- R6: A 16-bit accumulator (`accNarrow` = 0) adds one cycle in every form.
- R7: In 0x24 and 0x34 only, a nonzero `dpLow` adds one cycle.
- R8: In 0x3C only, one cycle is added when bits 16..8 of the 17-bit sum `baseAddr + xIndex` differ from bits 15..8 of `baseAddr`, which means the page changes.
- R9: The penalties add together, so 0x34 with a 16-bit accumulator and nonzero `dpLow` takes 6 cycles.
- R10: Any other opcode sets `invalidOp`, leaves all eight status bits equal to `flagsIn`, reports a length of 1 and takes 1 cycle.
- R11: `start` is accepted only while `busy` is low, and the inputs are captured at that edge. If `start` is sampled high in cycle c, then `done` is high for exactly one cycle, in cycle c + `cycleCount`. A `start` seen while busy is ignored, and input changes after acceptance have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| opcode | input | 8 | Instruction opcode byte |
| accNarrow | input | 1 | 1 = 8-bit accumulator, 0 = 16-bit |
| accVal | input | 16 | Accumulator value |
| operand | input | 16 | Fetched operand data |
| dpLow | input | 8 | Low byte of the direct page register |
| baseAddr | input | 16 | Unindexed base address (indexed absolute form) |
| xIndex | input | 16 | X index value |
| flagsIn | input | 8 | Status byte, bits N V M X D I Z C from 7 down to 0 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| flagsOut | output | 8 | Updated status byte |
| instLen | output | 2 | Instruction length in bytes |
| cycleCount | output | 4 | Total cycle count including penalties |
| invalidOp | output | 1 | Opcode is not a bit-test encoding |

## Verification
A corrupted captured request, such as a wrong width bit or a stale operand, appears in the first `done` cycle as a wrong Z, N or V bit, or as a cycle count one off. The bench changes every input right after acceptance, so any path that is not registered gives different results by the time `done` rises. A cycle counter that is off shifts `done` by at least one cycle, and the scoreboard sees this as a latency error on that same request. A lost or extra pulse shows up at the next completion as an empty-queue or leftover-item error.

// File: rtl/bt_pkg.sv
package bt_pkg;

  localparam logic [7:0] OP_IMM  = 8'h89;
  localparam logic [7:0] OP_ABS  = 8'h2C;
  localparam logic [7:0] OP_DP   = 8'h24;
  localparam logic [7:0] OP_ABSX = 8'h3C;
  localparam logic [7:0] OP_DPX  = 8'h34;

  localparam int FLAG_N = 7;
  localparam int FLAG_V = 6;
  localparam int FLAG_Z = 1;
  localparam logic [7:0] KEEP_MASK = 8'b0011_1101;

  typedef enum logic [2:0] {
    MODE_IMM,
    MODE_ABS,
    MODE_DP,
    MODE_ABSX,
    MODE_DPX,
    MODE_BAD
  } btMode_e;

  typedef struct packed {
    logic load;
    logic live;
  } btStrobe_t;

  function automatic btMode_e decodeMode(input logic [7:0] op);
    case (op)
      OP_IMM:  return MODE_IMM;
      OP_ABS:  return MODE_ABS;
      OP_DP:   return MODE_DP;
      OP_ABSX: return MODE_ABSX;
      OP_DPX:  return MODE_DPX;
      default: return MODE_BAD;
    endcase
  endfunction

  function automatic logic [2:0] baseCycles(input btMode_e m);
    case (m)
      MODE_IMM:  return 3'd2;
      MODE_ABS:  return 3'd4;
      MODE_DP:   return 3'd3;
      MODE_ABSX: return 3'd4;
      MODE_DPX:  return 3'd4;
      default:   return 3'd1;
    endcase
  endfunction

  function automatic logic [1:0] baseLength(input btMode_e m);
    case (m)
      MODE_IMM:  return 2'd2;
      MODE_ABS:  return 2'd3;
      MODE_DP:   return 2'd2;
      MODE_ABSX: return 2'd3;
      MODE_DPX:  return 2'd2;
      default:   return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/bt_datapath.sv
module bt_datapath
  import bt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  btStrobe_t         strobe,
  input  logic [7:0]        opcode,
  input  logic              accNarrow,
  input  logic [DATA_W-1:0] accVal,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W/2-1:0] dpLow,
  input  logic [DATA_W-1:0] baseAddr,
  input  logic [DATA_W-1:0] xIndex,
  input  logic [7:0]        flagsIn,
  output logic [7:0]        flagsOut,
  output logic [1:0]        instLen,
  output logic [CNT_W-1:0]  cycleCount,
  output logic              invalidOp
);

  localparam int HALF = DATA_W / 2;

  logic [7:0]        opR;
  logic              narrowR;
  logic [DATA_W-1:0] accR;
  logic [DATA_W-1:0] opdR;
  logic              dpNzR;
  logic [DATA_W-1:0] baseR;
  logic [DATA_W-1:0] xR;
  logic [7:0]        flagsR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR     <= 8'h00;
      narrowR <= 1'b1;
      accR    <= '0;
      opdR    <= '0;
      dpNzR   <= 1'b0;
      baseR   <= '0;
      xR      <= '0;
      flagsR  <= 8'h00;
    end else if (strobe.load) begin
      opR     <= opcode;
      narrowR <= accNarrow;
      accR    <= accVal;
      opdR    <= operand;
      dpNzR   <= |dpLow;
      baseR   <= baseAddr;
      xR      <= xIndex;
      flagsR  <= flagsIn;
    end
  end

  btMode_e mode;
  assign mode      = decodeMode(opR);
  assign invalidOp = (mode == MODE_BAD);

  // Lane mask: the upper half of the data path drops out in 8-bit mode.
  logic [DATA_W-1:0] laneMask;
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    if (i < HALF) begin : g_low
      assign laneMask[i] = 1'b1;
    end else begin : g_high
      assign laneMask[i] = ~narrowR;
    end
  end

  logic [DATA_W-1:0] andRes;
  logic              topBit;
  logic              nextBit;
  assign andRes  = accR & opdR & laneMask;
  assign topBit  = narrowR ? opdR[HALF-1] : opdR[DATA_W-1];
  assign nextBit = narrowR ? opdR[HALF-2] : opdR[DATA_W-2];

  always_comb begin
    flagsOut = flagsR;
    if (mode != MODE_BAD) begin
      flagsOut[FLAG_Z] = ~|andRes;
      if (mode != MODE_IMM) begin
        flagsOut[FLAG_N] = topBit;
        flagsOut[FLAG_V] = nextBit;
      end
    end
  end

  // Timing penalties
  logic widePen;
  logic dpPen;
  logic pagePen;
  logic pageMoved;
  assign pageMoved = ((({1'b0, baseR} + {1'b0, xR}) >> HALF) != ({1'b0, baseR} >> HALF));
  assign widePen   = (mode != MODE_BAD) && !narrowR;
  assign dpPen     = dpNzR && ((mode == MODE_DP) || (mode == MODE_DPX));
  assign pagePen   = (mode == MODE_ABSX) && pageMoved;

  assign cycleCount = CNT_W'(baseCycles(mode)) + CNT_W'(widePen)
                    + CNT_W'(dpPen) + CNT_W'(pagePen);

  always_comb begin
    instLen = baseLength(mode);
    if ((mode == MODE_IMM) && !narrowR) instLen = 2'd3;
  end

  // Assertions
  a_r4_others_kept: assert property (@(posedge clk) disable iff (!rstN)
    (flagsOut & KEEP_MASK) == (flagsR & KEEP_MASK));
  a_r3_imm_nv_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.live && mode == MODE_IMM) |-> flagsOut[7:6] == flagsR[7:6]);
  a_r10_bad_untouched: assert property (@(posedge clk) disable iff (!rstN)
    invalidOp |-> (flagsOut == flagsR && cycleCount == CNT_W'(1) && instLen == 2'd1));
  a_r9_cycle_bound: assert property (@(posedge clk) disable iff (!rstN)
    (cycleCount >= CNT_W'(1)) && (cycleCount <= CNT_W'(6)));
  a_r1_len_range: assert property (@(posedge clk) disable iff (!rstN)
    !invalidOp |-> (instLen == 2'd2 || instLen == 2'd3));

endmodule

// File: rtl/bt_control.sv
module bt_control
  import bt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] cycleCount,
  output btStrobe_t        strobe,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] elapsed;

  assign strobe.load = start && !busy;
  assign strobe.live = busy;
  assign done        = busy && (elapsed == cycleCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      elapsed <= '0;
    end else if (strobe.load) begin
      busy    <= 1'b1;
      elapsed <= CNT_W'(1);
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
      end else begin
        elapsed <= elapsed + CNT_W'(1);
      end
    end
  end

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r11_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  a_r11_done_release: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic              accNarrow,
  input  logic [DATA_W-1:0] accVal,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W/2-1:0] dpLow,
  input  logic [DATA_W-1:0] baseAddr,
  input  logic [DATA_W-1:0] xIndex,
  input  logic [7:0]        flagsIn,
  output logic              busy,
  output logic              done,
  output logic [7:0]        flagsOut,
  output logic [1:0]        instLen,
  output logic [CNT_W-1:0]  cycleCount,
  output logic              invalidOp
);

  bt_pkg::btStrobe_t strobe;

  bt_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .cycleCount (cycleCount),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  bt_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opcode     (opcode),
    .accNarrow  (accNarrow),
    .accVal     (accVal),
    .operand    (operand),
    .dpLow      (dpLow),
    .baseAddr   (baseAddr),
    .xIndex     (xIndex),
    .flagsIn    (flagsIn),
    .flagsOut   (flagsOut),
    .instLen    (instLen),
    .cycleCount (cycleCount),
    .invalidOp  (invalidOp)
  );

endmodule

// File: tb/bit_test_unit_bench.sv
`timescale 1ns/1ps
module bit_test_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        accNarrow = 1'b1;
  logic [15:0] accVal = '0;
  logic [15:0] operand = '0;
  logic [7:0]  dpLow = '0;
  logic [15:0] baseAddr = '0;
  logic [15:0] xIndex = '0;
  logic [7:0]  flagsIn = '0;
  logic        busy;
  logic        done;
  logic [7:0]  flagsOut;
  logic [1:0]  instLen;
  logic [3:0]  cycleCount;
  logic        invalidOp;

  always #2.5 clk = ~clk;

  bit_test_unit u_bit_test_unit (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .accNarrow(accNarrow),
    .accVal(accVal), .operand(operand), .dpLow(dpLow), .baseAddr(baseAddr),
    .xIndex(xIndex), .flagsIn(flagsIn), .busy(busy), .done(done),
    .flagsOut(flagsOut), .instLen(instLen), .cycleCount(cycleCount),
    .invalidOp(invalidOp)
  );

  typedef struct {
    logic [7:0] flags;
    logic [1:0] len;
    logic [3:0] cyc;
    logic       inv;
    int         startTick;
    string      tag;
  } item_t;

  item_t expQ[$];
  int    checks = 0;
  int    fails  = 0;
  int    tick   = 0;
  bit    ended  = 1'b0;

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // Expected result computed from the requirements
  function automatic item_t predict(input logic [7:0] op, input logic narrow,
      input logic [15:0] acc, input logic [15:0] opd, input logic [7:0] dp,
      input logic [15:0] base, input logic [15:0] x, input logic [7:0] fl,
      input string tag);
    item_t it;
    int    cyc;
    int    len;
    bit    valid;
    bit    isDp;
    logic [16:0] sum;
    valid = 1'b1;
    isDp  = 1'b0;
    case (op)
      8'h89: begin cyc = 2; len = narrow ? 2 : 3; end
      8'h2C: begin cyc = 4; len = 3; end
      8'h24: begin cyc = 3; len = 2; isDp = 1'b1; end
      8'h3C: begin cyc = 4; len = 3; end
      8'h34: begin cyc = 4; len = 2; isDp = 1'b1; end
      default: begin cyc = 1; len = 1; valid = 1'b0; end
    endcase
    it.flags = fl;
    if (valid) begin
      if (!narrow) cyc++;
      if (isDp && dp != 8'h00) cyc++;
      sum = {1'b0, base} + {1'b0, x};
      if (op == 8'h3C && sum[16:8] != {1'b0, base[15:8]}) cyc++;
      it.flags[1] = narrow ? ((acc[7:0] & opd[7:0]) == 8'h00) : ((acc & opd) == 16'h0000);
      if (op != 8'h89) begin
        it.flags[7] = narrow ? opd[7] : opd[15];
        it.flags[6] = narrow ? opd[6] : opd[14];
      end
    end
    it.cyc = 4'(cyc);
    it.len = 2'(len);
    it.inv = !valid;
    it.startTick = 0;
    it.tag = tag;
    return it;
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    item_t e;
    tick++;
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check("R11", "unexpected done", 1, 0);
      end else begin
        e = expQ.pop_front();
        check(e.tag, "flags", int'(flagsOut), int'(e.flags));
        check(e.tag, "length", int'(instLen), int'(e.len));
        check(e.tag, "cycles", int'(cycleCount), int'(e.cyc));
        check(e.tag, "invalid", int'(invalidOp), int'(e.inv));
        check("R11", {e.tag, " latency"}, tick - e.startTick, int'(e.cyc));
      end
    end
  end

  task automatic run(input logic [7:0] op, input logic narrow, input logic [15:0] acc,
      input logic [15:0] opd, input logic [7:0] dp, input logic [15:0] base,
      input logic [15:0] x, input logic [7:0] fl, input string tag, input bit poke);
    item_t it;
    @(negedge clk); #1;
    opcode = op; accNarrow = narrow; accVal = acc; operand = opd;
    dpLow = dp; baseAddr = base; xIndex = x; flagsIn = fl;
    start = 1'b1;
    it = predict(op, narrow, acc, opd, dp, base, x, fl, tag);
    it.startTick = tick;
    expQ.push_back(it);
    @(negedge clk); #1;
    // Scramble all inputs after acceptance: captured values must be used (R11)
    opcode = 8'h2C; accNarrow = ~narrow; accVal = ~acc; operand = ~opd;
    dpLow = ~dp; baseAddr = ~base; xIndex = ~x; flagsIn = ~fl;
    start = poke;  // a start while busy must be ignored (R11)
    @(negedge clk); #1;
    start = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", "timeout", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "busy in reset", int'(busy), 0);
    check("R11", "done in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "busy after reset", int'(busy), 0);
    check("R11", "done after reset", int'(done), 0);

    // R1 R2 R3 R5: immediate, 8-bit, zero result, N/V kept
    run(8'h89, 1'b1, 16'h000F, 16'h00F0, 8'h00, 16'h0000, 16'h0000, 8'hC0, "R3", 1'b0);
    // R1 R6: immediate with 16-bit accumulator is 3 bytes, 3 cycles
    run(8'h89, 1'b0, 16'h0100, 16'h0100, 8'h00, 16'h0000, 16'h0000, 8'h02, "R1", 1'b1);
    // R3 R4: absolute, 8-bit, N and V from bits 7/6, others kept
    run(8'h2C, 1'b1, 16'h0040, 16'h00C0, 8'h00, 16'h0000, 16'h0000, 8'h3D, "R4", 1'b0);
    // R2 R3 R6: absolute, 16-bit, bits 15/14
    run(8'h2C, 1'b0, 16'h00FF, 16'h4000, 8'h00, 16'h0000, 16'h0000, 8'h80, "R6", 1'b1);
    // R2: 8-bit mode ignores the upper byte
    run(8'h2C, 1'b1, 16'hFF00, 16'hFF00, 8'h00, 16'h0000, 16'h0000, 8'h00, "R2", 1'b0);
    // R7: absolute ignores the direct page byte
    run(8'h2C, 1'b1, 16'h0001, 16'h0001, 8'h05, 16'h0000, 16'h0000, 8'h00, "R7", 1'b0);
    // R5 R7: direct page with zero and nonzero low byte
    run(8'h24, 1'b1, 16'h0080, 16'h0080, 8'h00, 16'h0000, 16'h0000, 8'h00, "R5", 1'b0);
    run(8'h24, 1'b1, 16'h0080, 16'h0080, 8'h01, 16'h0000, 16'h0000, 8'h00, "R7", 1'b1);
    // R8: direct page ignores a page-crossing index sum
    run(8'h24, 1'b1, 16'h0001, 16'h0002, 8'h00, 16'h10F0, 16'h0020, 8'h00, "R8", 1'b0);
    // R9: direct page indexed, 16-bit, nonzero dp -> 6 cycles
    run(8'h34, 1'b0, 16'hFFFF, 16'h8000, 8'h80, 16'h0000, 16'h0000, 8'h41, "R9", 1'b0);
    run(8'h34, 1'b1, 16'h0000, 16'h0040, 8'h00, 16'h0000, 16'h0000, 8'hFF, "R5", 1'b0);
    // R8: absolute indexed, crossing and non-crossing
    run(8'h3C, 1'b1, 16'h0003, 16'h0001, 8'h00, 16'h10F0, 16'h0010, 8'h00, "R8", 1'b0);
    run(8'h3C, 1'b1, 16'h0003, 16'h0001, 8'h00, 16'h1000, 16'h00FF, 8'h00, "R8", 1'b1);
    run(8'h3C, 1'b0, 16'h0003, 16'h0001, 8'h33, 16'h12FF, 16'h0001, 8'h00, "R9", 1'b0);
    run(8'h3C, 1'b1, 16'h0000, 16'h0000, 8'h00, 16'hFF80, 16'h0100, 8'h00, "R8", 1'b0);
    // R10: invalid opcodes
    run(8'h00, 1'b1, 16'h0000, 16'hFFFF, 8'h10, 16'h0000, 16'h0000, 8'hA5, "R10", 1'b0);
    run(8'hFF, 1'b0, 16'h1234, 16'h5678, 8'h00, 16'h0000, 16'h0000, 8'h5A, "R10", 1'b1);

    repeat (5) @(negedge clk);
    check("R11", "queue drained", expQ.size(), 0);
    check("R11", "idle at end", int'(busy), 0);
    finishRun();
  end

endmodule